// File: doc/BRIEF.md
# Oldest-First Issue Selector

This block holds decoded non-memory micro-ops waiting to execute and picks which of them leave each cycle. Every cycle it walks its held entries from oldest to youngest. An entry is taken only if its source operands are ready and a functional unit of the class it needs is free. Entries that fail either test are passed over, and the walk goes on to younger ones. The walk stops once a per-cycle quantum of issues is reached.

Each issued micro-op leaves the queue. The survivors close ranks so that age order is kept. The issue port carries the micro-op's opcode and its completion cycle, which is the current cycle count plus the latency of its unit class. A micro-op that needs no unit still takes one cycle. Readiness, once seen, is latched per entry, so a later drop of the external ready line does not hold the entry back. The block also keeps running totals of queue reads and of integer and floating-point register-file reads.

Top module: `issue_select`

## Requirements
- R1: After reset the queue is empty, no issue slot is valid, all three read totals are zero and `cur_cycle` is zero. `cur_cycle` then rises by one on every clock.
- R2: A micro-op offered with `enq_valid` is appended as the youngest entry when `occupancy` is below DEPTH (16). At DEPTH it is dropped and `occupancy` stays at 16.
- R3: A micro-op offered with `enq_mem`=1 is refused and never enters the queue.
- R4: Entries are examined oldest first, and at most QUANT (4) issue per cycle. Issue slot 0 carries the oldest issued entry, with younger ones in higher slots. Entries past the point where the quantum is reached are not examined.
- R5: An entry whose operands are not ready (its sticky bit is clear and `opnd_rdy` at its position is 0) is skipped, and younger entries are still examined. Bit i of `opnd_rdy` belongs to the i-th oldest held entry.
- R6: An examined entry seen ready keeps a sticky ready flag. It can issue in a later cycle even if `opnd_rdy` has fallen by then.
- R7: Class encoding: 0 = none, 1 = integer add (2 units), 2 = integer multiply (1 unit), 3 = divide (1 unit). A ready entry whose class has no free unit left this cycle is skipped and stays queued.
- R8: Class 0 needs no unit, so it is never blocked by unit availability.
- R9: The completion cycle is `cur_cycle` plus the latency: class 0 = 1, class 1 = 1, class 2 = 3, class 3 = 20.
- R10: A reserved unit stays busy for its class interval: 1 cycle for classes 1 and 2, 20 cycles for class 3. A second divide issues exactly 20 cycles after the first.
- R11: Issued entries leave at the clock edge. The remaining entries keep their relative age order and compact towards position 0.
- R12: Each clock adds the number of issues to `iq_reads`, and the issued entries' integer and floating-point source counts to `rf_int_reads` and `rf_fp_reads`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Offer a micro-op this cycle |
| enq_mem | input | 1 | Offered micro-op accesses memory (refused) |
| enq_cls | input | 2 | Unit class of the offered micro-op |
| enq_opc | input | 8 | Opcode of the offered micro-op |
| enq_nint | input | 2 | Integer physical source count |
| enq_nfp | input | 2 | Floating-point physical source count |
| opnd_rdy | input | 16 | Operand-ready flag per held position, oldest at bit 0 |
| occupancy | output | 5 | Number of held entries |
| cur_cycle | output | 16 | Cycles since reset |
| iss_valid | output | 4 | Issue slot valid, slot 0 oldest |
| iss_opc | output | 32 | Opcode per slot, slot k at bits 8k+7:8k |
| iss_done | output | 64 | Completion cycle per slot, slot k at bits 16k+15:16k |
| iq_reads | output | 16 | Total issues |
| rf_int_reads | output | 16 | Total integer register reads |
| rf_fp_reads | output | 16 | Total floating-point register reads |

## Verification
The issue slots are combinational: they are due in the same cycle in which `opnd_rdy` and the held state present a choice. The bench therefore drives inputs on the falling edge and reads the slots one time unit later, before the rising edge that commits the choice. Occupancy, the read totals and the unit timers change at that rising edge, so the bench checks them one time unit after it. The divide interval is checked one cycle at a time: the slots must stay empty for 19 cycles after the first divide issues, and the second divide must issue in the 20th.

// File: rtl/issue_select.sv
module issue_select #(
  parameter int DEPTH = 16,
  parameter int QUANT = 4,
  parameter int OPW   = 8,
  parameter int CW    = 16,
  parameter int CNTW  = 16,
  parameter int NCLS  = 4,
  parameter int MAXU  = 2,
  parameter logic [NCLS*8-1:0] CLS_LAT   = {8'd20, 8'd3, 8'd1, 8'd1},
  parameter logic [NCLS*8-1:0] CLS_UNITS = {8'd1,  8'd1, 8'd2, 8'd0},
  parameter logic [NCLS*8-1:0] CLS_IVL   = {8'd20, 8'd1, 8'd1, 8'd1},
  localparam int CLW = $clog2(NCLS),
  localparam int OCW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enq_valid,
  input  logic                enq_mem,
  input  logic [CLW-1:0]      enq_cls,
  input  logic [OPW-1:0]      enq_opc,
  input  logic [1:0]          enq_nint,
  input  logic [1:0]          enq_nfp,
  input  logic [DEPTH-1:0]    opnd_rdy,
  output logic [OCW-1:0]      occupancy,
  output logic [CW-1:0]       cur_cycle,
  output logic [QUANT-1:0]    iss_valid,
  output logic [QUANT*OPW-1:0] iss_opc,
  output logic [QUANT*CW-1:0] iss_done,
  output logic [CNTW-1:0]     iq_reads,
  output logic [CNTW-1:0]     rf_int_reads,
  output logic [CNTW-1:0]     rf_fp_reads
);

  logic [CLW-1:0] e_cls [DEPTH], n_cls [DEPTH];
  logic [OPW-1:0] e_opc [DEPTH], n_opc [DEPTH];
  logic [1:0]     e_ni  [DEPTH], n_ni  [DEPTH];
  logic [1:0]     e_nf  [DEPTH], n_nf  [DEPTH];
  logic [DEPTH-1:0] e_rdy, n_rdy, iss_vec, seen;
  logic [OCW-1:0] occ, occ_nx;
  logic [CW-1:0]  cyc;
  logic [7:0]     tmr [NCLS][MAXU], tmr_nx [NCLS][MAXU];
  logic [7:0]     free_cnt [NCLS], used [NCLS];
  logic [OPW-1:0] s_opc [QUANT];
  logic [CW-1:0]  s_done [QUANT];
  logic [QUANT-1:0] s_vld;
  logic [CNTW-1:0] int_sum, fp_sum, q_cnt, int_tot, fp_tot;
  int taken, k;
  logic accept;

  function automatic logic [7:0] lat_of(input logic [CLW-1:0] c);
    return (c == '0) ? 8'd1 : CLS_LAT[int'(c)*8 +: 8];
  endfunction

  assign accept = enq_valid && !enq_mem && (int'(occ) < DEPTH);

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      free_cnt[c] = '0;
      for (int u = 0; u < MAXU; u++)
        if (u < int'(CLS_UNITS[c*8 +: 8]) && tmr[c][u] == '0) free_cnt[c] = free_cnt[c] + 8'd1;
    end
  end

  always_comb begin
    taken = 0; iss_vec = '0; seen = '0; int_sum = '0; fp_sum = '0; s_vld = '0;
    for (int c = 0; c < NCLS; c++) used[c] = '0;
    for (int q = 0; q < QUANT; q++) begin s_opc[q] = '0; s_done[q] = '0; end
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(occ) && taken < QUANT && (e_rdy[i] || opnd_rdy[i])) begin
        seen[i] = 1'b1;
        if (e_cls[i] == '0 || used[e_cls[i]] < free_cnt[e_cls[i]]) begin
          if (e_cls[i] != '0) used[e_cls[i]] = used[e_cls[i]] + 8'd1;
          iss_vec[i]    = 1'b1;
          s_vld[taken]  = 1'b1;
          s_opc[taken]  = e_opc[i];
          s_done[taken] = cyc + CW'(lat_of(e_cls[i]));
          int_sum = int_sum + CNTW'(e_ni[i]);
          fp_sum  = fp_sum + CNTW'(e_nf[i]);
          taken = taken + 1;
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      int g;
      g = 0;
      for (int u = 0; u < MAXU; u++) begin
        tmr_nx[c][u] = (tmr[c][u] == '0) ? 8'd0 : tmr[c][u] - 8'd1;
        if (u < int'(CLS_UNITS[c*8 +: 8]) && tmr[c][u] == '0 && g < int'(used[c])) begin
          tmr_nx[c][u] = CLS_IVL[c*8 +: 8] - 8'd1;
          g = g + 1;
        end
      end
    end
  end

  always_comb begin
    k = 0; n_rdy = '0;
    for (int j = 0; j < DEPTH; j++) begin n_cls[j] = '0; n_opc[j] = '0; n_ni[j] = '0; n_nf[j] = '0; end
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(occ) && !iss_vec[i]) begin
        n_cls[k] = e_cls[i]; n_opc[k] = e_opc[i]; n_ni[k] = e_ni[i]; n_nf[k] = e_nf[i];
        n_rdy[k] = e_rdy[i] | seen[i];
        k = k + 1;
      end
    end
    if (accept) begin
      n_cls[k] = enq_cls; n_opc[k] = enq_opc; n_ni[k] = enq_nint; n_nf[k] = enq_nfp;
      n_rdy[k] = 1'b0;
      k = k + 1;
    end
    occ_nx = OCW'(k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0; cyc <= '0; e_rdy <= '0;
      q_cnt <= '0; int_tot <= '0; fp_tot <= '0;
      for (int j = 0; j < DEPTH; j++) begin e_cls[j] <= '0; e_opc[j] <= '0; e_ni[j] <= '0; e_nf[j] <= '0; end
      for (int c = 0; c < NCLS; c++) for (int u = 0; u < MAXU; u++) tmr[c][u] <= '0;
    end else begin
      occ <= occ_nx; cyc <= cyc + CW'(1); e_rdy <= n_rdy;
      q_cnt   <= q_cnt + CNTW'(taken);
      int_tot <= int_tot + int_sum;
      fp_tot  <= fp_tot + fp_sum;
      for (int j = 0; j < DEPTH; j++) begin e_cls[j] <= n_cls[j]; e_opc[j] <= n_opc[j]; e_ni[j] <= n_ni[j]; e_nf[j] <= n_nf[j]; end
      for (int c = 0; c < NCLS; c++) for (int u = 0; u < MAXU; u++) tmr[c][u] <= tmr_nx[c][u];
    end
  end

  for (genvar q = 0; q < QUANT; q++) begin : g_slot
    assign iss_opc[q*OPW +: OPW] = s_opc[q];
    assign iss_done[q*CW +: CW]  = s_done[q];
  end

  assign iss_valid    = s_vld;
  assign occupancy    = occ;
  assign cur_cycle    = cyc;
  assign iq_reads     = q_cnt;
  assign rf_int_reads = int_tot;
  assign rf_fp_reads  = fp_tot;

  AST_OCC_MAX:     assert property (@(posedge clk) disable iff (!rst_n) int'(occupancy) <= DEPTH); // R2
  AST_MEM_REFUSED: assert property (@(posedge clk) disable iff (!rst_n) (enq_valid && enq_mem) |=> occupancy <= $past(occupancy)); // R3
  AST_LAT_MIN:     assert property (@(posedge clk) disable iff (!rst_n) iss_valid[0] |-> iss_done[CW-1:0] != cur_cycle); // R9
  AST_CYC_STEP:    assert property (@(posedge clk) disable iff (!rst_n) rst_n |=> cur_cycle == $past(cur_cycle) + CW'(1)); // R1
  AST_READ_COUNT:  assert property (@(posedge clk) disable iff (!rst_n) rst_n |=> iq_reads == $past(iq_reads) + CNTW'($past($countones(iss_valid)))); // R12
  AST_OCC_FLOW:    assert property (@(posedge clk) disable iff (!rst_n) rst_n |=> int'(occupancy) == int'($past(occupancy)) - $past($countones(iss_valid)) + int'($past(accept))); // R11

endmodule

// File: tb/issue_select_test.sv
module issue_select_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_valid = 0, enq_mem = 0;
  logic [1:0] enq_cls = 0, enq_nint = 0, enq_nfp = 0;
  logic [7:0] enq_opc = 0;
  logic [15:0] opnd_rdy = 0;
  logic [4:0] occupancy;
  logic [15:0] cur_cycle, iq_reads, rf_int_reads, rf_fp_reads;
  logic [3:0] iss_valid;
  logic [31:0] iss_opc;
  logic [63:0] iss_done;
  int total = 0, bad = 0;
  bit finished = 0;

  issue_select uut (.clk, .rst_n, .enq_valid, .enq_mem, .enq_cls, .enq_opc, .enq_nint, .enq_nfp,
    .opnd_rdy, .occupancy, .cur_cycle, .iss_valid, .iss_opc, .iss_done, .iq_reads, .rf_int_reads, .rf_fp_reads);

  always #4 clk = ~clk;

  // {cls c5..c0, ready mask, issue count, slot positions p3..p0}
  localparam logic [32:0] VEC [6] = '{
    {12'b010101010101, 6'b111111, 3'd2, 3'd0, 3'd0, 3'd1, 3'd0},
    {12'b000000000000, 6'b111111, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
    {12'b000100011010, 6'b111111, 3'd4, 3'd4, 3'd3, 3'd2, 3'd0},
    {12'b000000000000, 6'b101010, 3'd3, 3'd0, 3'd5, 3'd3, 3'd1},
    {12'b010101001111, 6'b111110, 3'd4, 3'd4, 3'd3, 3'd2, 3'd1},
    {12'b010101010101, 6'b000000, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0}
  };

  function automatic int lat(input int c);
    return (c == 3) ? 20 : (c == 2) ? 3 : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0; enq_valid = 0; opnd_rdy = 0;
    @(negedge clk); rst_n = 1; #1;
  endtask

  task automatic tick; @(posedge clk); #1; endtask

  task automatic enq(input int c, input int o, input int ni, input int nf, input bit m);
    @(negedge clk);
    enq_valid = 1; enq_cls = 2'(c); enq_opc = 8'(o); enq_nint = 2'(ni); enq_nfp = 2'(nf); enq_mem = m;
    tick; enq_valid = 0; enq_mem = 0;
  endtask

  task automatic set_rdy(input logic [15:0] m); @(negedge clk); opnd_rdy = m; #1; endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset;
    chk(occupancy == 0, "R1 occupancy", occupancy, 0);
    chk(iss_valid == 0, "R1 iss_valid", iss_valid, 0);
    chk(iq_reads == 0 && rf_int_reads == 0 && rf_fp_reads == 0, "R1 totals", iq_reads, 0);
    chk(cur_cycle == 0, "R1 cur_cycle", cur_cycle, 0);

    // table walk: R4 R5 R7 R8 R9 R11
    foreach (VEC[v]) begin
      logic [11:0] cl; logic [5:0] rm; int cnt, base;
      cl = VEC[v][32:21]; rm = VEC[v][20:15]; cnt = int'(VEC[v][14:12]);
      do_reset;
      for (int p = 0; p < 6; p++) enq(int'(cl[2*p +: 2]), 16 + p, 1, 0, 0);
      chk(occupancy == 6, "R2 fill", occupancy, 6);
      set_rdy({10'b0, rm});
      base = int'(cur_cycle);
      for (int s = 0; s < 4; s++) begin
        int p;
        p = int'(VEC[v][3*s +: 3]);
        if (s < cnt) begin
          chk(iss_valid[s] == 1'b1, "R4 R5 R7 slot valid", iss_valid[s], 1);
          chk(int'(iss_opc[8*s +: 8]) == 16 + p, "R4 slot order", iss_opc[8*s +: 8], 16 + p);
          chk(int'(iss_done[16*s +: 16]) == base + lat(int'(cl[2*p +: 2])), "R9 R8 done cycle",
              iss_done[16*s +: 16], base + lat(int'(cl[2*p +: 2])));
        end else
          chk(iss_valid[s] == 1'b0, "R4 R7 slot idle", iss_valid[s], 0);
      end
      tick;
      chk(int'(occupancy) == 6 - cnt, "R11 removal", occupancy, 6 - cnt);
    end

    // R12 read totals
    do_reset;
    enq(0, 1, 1, 0, 0); enq(0, 2, 2, 1, 0); enq(0, 3, 3, 3, 0);
    set_rdy(16'hffff); tick;
    chk(iq_reads == 3, "R12 iq_reads", iq_reads, 3);
    chk(rf_int_reads == 6, "R12 int reads", rf_int_reads, 6);
    chk(rf_fp_reads == 4, "R12 fp reads", rf_fp_reads, 4);
    chk(occupancy == 0, "R11 drained", occupancy, 0);

    // R3 memory micro-op refused
    do_reset;
    enq(0, 9, 0, 0, 1);
    chk(occupancy == 0, "R3 mem refused", occupancy, 0);

    // R2 full, R11 compaction order
    do_reset;
    for (int i = 0; i < 17; i++) enq(0, i, 0, 0, 0);
    chk(occupancy == 16, "R2 full drop", occupancy, 16);
    set_rdy(16'h8000);
    chk(iss_valid == 4'b0001 && iss_opc[7:0] == 15, "R5 youngest only", iss_opc[7:0], 15);
    tick;
    set_rdy(16'h0002);
    chk(iss_opc[7:0] == 1, "R11 order a", iss_opc[7:0], 1);
    tick;
    set_rdy(16'h0002);
    chk(iss_opc[7:0] == 2, "R11 compacted", iss_opc[7:0], 2);
    tick;

    // R6 sticky ready
    do_reset;
    enq(2, 8'ha0, 0, 0, 0); enq(2, 8'hb0, 0, 0, 0);
    set_rdy(16'h0003);
    chk(iss_valid == 4'b0001 && iss_opc[7:0] == 8'ha0, "R7 one multiplier", iss_opc[7:0], 8'ha0);
    tick;
    set_rdy(16'h0000);
    chk(iss_valid[0] && iss_opc[7:0] == 8'hb0, "R6 sticky", iss_opc[7:0], 8'hb0);
    chk(int'(iss_done[15:0]) == int'(cur_cycle) + 3, "R9 mul latency", iss_done[15:0], int'(cur_cycle) + 3);
    tick;

    // R10 divide interval
    do_reset;
    enq(3, 8'hd1, 0, 0, 0); enq(3, 8'hd2, 0, 0, 0);
    set_rdy(16'hffff);
    chk(iss_valid == 4'b0001 && iss_opc[7:0] == 8'hd1, "R10 first divide", iss_opc[7:0], 8'hd1);
    tick;
    for (int t = 1; t < 20; t++) begin
      #1;
      chk(iss_valid == 0, "R10 divider busy", iss_valid, 0);
      tick;
    end
    chk(iss_valid[0] && iss_opc[7:0] == 8'hd2, "R10 second divide", iss_opc[7:0], 8'hd2);
    tick;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule